// File: doc/BRIEF.md
# Fixed-Priority Vectored Interrupt Controller

This block gathers eight interrupt request lines and presents them to a host processor as one interrupt output. Each request is recorded in a pending register. A per-line mask decides whether the request may reach the host. A fixed-priority resolver then picks the most urgent unmasked request. It forwards that request only when the request outranks every level whose service is still open, so interrupts nest by priority.

The host answers the interrupt with two acknowledge pulses. The first pulse freezes the choice and leaves the data bus alone. The second pulse drives an 8-bit vector: a programmable 5-bit base joined to the 3-bit level number. On that same edge the level moves from the pending register into the in-service register. Software ends service with an end-of-interrupt command, which retires the most urgent open level. Each line can be set to follow its input level or to latch a rising edge. The host interface has a chip select, one address bit, read and write strobes, and separate read and write data buses with a drive enable.

Top module: `prio_irq_ctrl`

## Requirements
- R1: After reset the pending, in-service, mask and trigger-mode registers and the vector base are all zero, the command pointer selects the mask, and irq_out and rdata_oe are low.
- R2: A line whose trigger-mode bit is 0 (level mode) has a pending bit equal to its input as sampled on the previous clock edge.
- R3: A line whose trigger-mode bit is 1 (edge mode) sets its pending bit on a 0-to-1 input transition. The bit then stays set after the input falls, until that level is acknowledged.
- R4: A mask bit of 1 keeps its line from raising irq_out, although the pending bit still records the request. A mask bit of 0 lets the line through.
- R5: Line 0 has the highest priority and line 7 the lowest. irq_out is high exactly when some unmasked pending line exists whose number is lower than every set in-service bit.
- R6: During the first acknowledge pulse the block does not drive the data bus (rdata_oe low when no host read is active), and it latches the resolver's choice.
- R7: During the second acknowledge pulse the block drives the vector {base[4:0], level[2:0]} with rdata_oe high. At the end of that pulse the level's in-service bit is set and its pending bit is cleared.
- R8: If no request qualifies at the first pulse, the second pulse drives level 7 with the current base, and the in-service register is left unchanged.
- R9: A write to address 0 with data bit 5 set (end of interrupt) clears the lowest-numbered set in-service bit.
- R10: A write to address 0 loads the command pointer from data bits [7:6]: 00 mask, 01 trigger mode, 10 base in bits [7:3], 11 in-service (read-only). A write to address 1 loads the selected register. A read of address 1 returns the selected register, and a read of address 0 returns the pending register. Accesses without chip select have no effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cs | input | 1 | Chip select, active high |
| addr | input | 1 | Register address bit |
| rd | input | 1 | Read strobe |
| wr | input | 1 | Write strobe |
| wdata | input | 8 | Host write data |
| rdata | output | 8 | Read data or interrupt vector |
| rdata_oe | output | 1 | High while rdata should be driven onto the bus |
| irq_req | input | 8 | Interrupt request lines, line 0 most urgent |
| irq_out | output | 1 | Interrupt request toward the host |
| ack | input | 1 | Acknowledge pulse, one cycle per pulse |

## Verification
The assertions assume that every request line and host strobe is synchronous to clk. They also assume that each acknowledge pulse lasts exactly one cycle and comes in pairs, and that a host read never overlaps the first acknowledge pulse. The bench changes inputs only on falling edges and holds ack for a single cycle per pulse, with an idle cycle between the two pulses. It keeps host reads apart from acknowledge pulses and never sends an end-of-interrupt write in the same cycle as a second pulse.

// File: rtl/pic_pkg.sv
package pic_pkg;
  typedef enum logic [1:0] {
    SEL_MASK = 2'b00,
    SEL_TRIG = 2'b01,
    SEL_BASE = 2'b10,
    SEL_ISR  = 2'b11
  } reg_sel_e;

  localparam int EOI_BIT = 5;
endpackage

// File: rtl/pic_req_reg.sv
module pic_req_reg #(
  parameter int N = 8
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [N-1:0] req_in,
  input  logic [N-1:0] edge_sel,
  input  logic [N-1:0] clr,
  output logic [N-1:0] irr
);
  for (genvar i = 0; i < N; i++) begin : g_bit
    logic prev_q, prev_d;
    logic irr_q, irr_d;
    logic rise;

    always_comb begin
      rise   = req_in[i] & ~prev_q;
      prev_d = req_in[i];
      if (clr[i])           irr_d = 1'b0;
      else if (edge_sel[i]) irr_d = irr_q | rise;
      else                  irr_d = req_in[i];
    end

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        prev_q <= 1'b0;
        irr_q  <= 1'b0;
      end else begin
        prev_q <= prev_d;
        irr_q  <= irr_d;
      end
    end

    assign irr[i] = irr_q;

    a_r3_edge_hold: assert property (@(posedge clk) disable iff (!rst_n)
      (irr_q && edge_sel[i] && !clr[i]) |=> irr_q);

    a_r2_level_follow: assert property (@(posedge clk) disable iff (!rst_n)
      (!edge_sel[i] && !clr[i]) |=> (irr_q == $past(req_in[i])));
  end
endmodule

// File: rtl/pic_prio_find.sv
module pic_prio_find #(
  parameter int N = 8,
  localparam int W = $clog2(N)
) (
  input  logic [N-1:0] vec,
  output logic         any,
  output logic [W-1:0] idx
);
  always_comb begin
    any = 1'b0;
    idx = '0;
    for (int i = N - 1; i >= 0; i--) begin
      if (vec[i]) begin
        any = 1'b1;
        idx = W'(i);
      end
    end
  end
endmodule

// File: rtl/pic_ack_seq.sv
module pic_ack_seq #(
  parameter int LVL_W = 3
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             ack,
  input  logic             grant_ok,
  input  logic [LVL_W-1:0] grant_lvl,
  output logic             take,
  output logic             lat_valid,
  output logic [LVL_W-1:0] lat_lvl,
  output logic             vec_oe
);
  logic             phase_q, phase_d;
  logic             valid_q, valid_d;
  logic [LVL_W-1:0] lvl_q, lvl_d;
  logic             first;

  always_comb begin
    first   = ack & ~phase_q;
    take    = ack & phase_q;
    phase_d = phase_q;
    valid_d = valid_q;
    lvl_d   = lvl_q;
    if (first) begin
      phase_d = 1'b1;
      valid_d = grant_ok;
      lvl_d   = grant_ok ? grant_lvl : '1;
    end else if (take) begin
      phase_d = 1'b0;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      phase_q <= 1'b0;
      valid_q <= 1'b0;
      lvl_q   <= '0;
    end else begin
      phase_q <= phase_d;
      valid_q <= valid_d;
      lvl_q   <= lvl_d;
    end
  end

  assign lat_valid = valid_q;
  assign lat_lvl   = lvl_q;
  assign vec_oe    = take;

  a_r6_first_quiet: assert property (@(posedge clk) disable iff (!rst_n)
    (ack && !phase_q) |-> !vec_oe);

  a_r6_single_drive: assert property (@(posedge clk) disable iff (!rst_n)
    vec_oe |=> !vec_oe);
endmodule

// File: rtl/prio_irq_ctrl.sv
module prio_irq_ctrl #(
  parameter int NUM_IRQ = 8,
  parameter int DATA_W  = 8
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               cs,
  input  logic               addr,
  input  logic               rd,
  input  logic               wr,
  input  logic [DATA_W-1:0]  wdata,
  output logic [DATA_W-1:0]  rdata,
  output logic               rdata_oe,
  input  logic [NUM_IRQ-1:0] irq_req,
  output logic               irq_out,
  input  logic               ack
);
  import pic_pkg::*;

  localparam int LVL_W  = $clog2(NUM_IRQ);
  localparam int BASE_W = DATA_W - LVL_W;

  // reset: asynchronous assert, synchronous release
  logic rst_m_q, rst_s_q;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rst_m_q <= 1'b0;
      rst_s_q <= 1'b0;
    end else begin
      rst_m_q <= 1'b1;
      rst_s_q <= rst_m_q;
    end
  end

  logic [NUM_IRQ-1:0] mask_q, mask_d, trig_q, trig_d, isr_q, isr_d;
  logic [BASE_W-1:0]  base_q, base_d;
  reg_sel_e           sel_q, sel_d;

  logic               wr0, wr1, eoi, rd_any;
  logic [NUM_IRQ-1:0] irr, pend, eoi_clr, isr_set;
  logic               pend_any, isr_any, grant_ok;
  logic [LVL_W-1:0]   pend_idx, isr_idx;
  logic               take, lat_valid, vec_oe;
  logic [LVL_W-1:0]   lat_lvl;
  logic [DATA_W-1:0]  reg_rd;

  assign wr0    = cs & wr & ~addr;
  assign wr1    = cs & wr & addr;
  assign rd_any = cs & rd;
  assign eoi    = wr0 & wdata[EOI_BIT];

  pic_req_reg #(.N(NUM_IRQ)) u_req (
    .clk(clk), .rst_n(rst_s_q), .req_in(irq_req),
    .edge_sel(trig_q), .clr(isr_set), .irr(irr)
  );

  assign pend = irr & ~mask_q;

  pic_prio_find #(.N(NUM_IRQ)) u_pend_find (
    .vec(pend), .any(pend_any), .idx(pend_idx)
  );

  pic_prio_find #(.N(NUM_IRQ)) u_isr_find (
    .vec(isr_q), .any(isr_any), .idx(isr_idx)
  );

  assign grant_ok = pend_any & (~isr_any | (pend_idx < isr_idx));
  assign irq_out  = grant_ok;

  pic_ack_seq #(.LVL_W(LVL_W)) u_ack (
    .clk(clk), .rst_n(rst_s_q), .ack(ack), .grant_ok(grant_ok),
    .grant_lvl(pend_idx), .take(take), .lat_valid(lat_valid),
    .lat_lvl(lat_lvl), .vec_oe(vec_oe)
  );

  always_comb begin
    sel_d   = wr0 ? reg_sel_e'(wdata[DATA_W-1 -: 2]) : sel_q;
    mask_d  = (wr1 && sel_q == SEL_MASK) ? wdata[NUM_IRQ-1:0] : mask_q;
    trig_d  = (wr1 && sel_q == SEL_TRIG) ? wdata[NUM_IRQ-1:0] : trig_q;
    base_d  = (wr1 && sel_q == SEL_BASE) ? wdata[DATA_W-1 -: BASE_W] : base_q;
    eoi_clr = (eoi && isr_any) ? (NUM_IRQ'(1) << isr_idx) : '0;
    isr_set = (take && lat_valid) ? (NUM_IRQ'(1) << lat_lvl) : '0;
    isr_d   = (isr_q & ~eoi_clr) | isr_set;
  end

  always_ff @(posedge clk or negedge rst_s_q) begin
    if (!rst_s_q) begin
      sel_q  <= SEL_MASK;
      mask_q <= '0;
      trig_q <= '0;
      base_q <= '0;
      isr_q  <= '0;
    end else begin
      sel_q  <= sel_d;
      mask_q <= mask_d;
      trig_q <= trig_d;
      base_q <= base_d;
      isr_q  <= isr_d;
    end
  end

  always_comb begin
    if (!addr) begin
      reg_rd = DATA_W'(irr);
    end else begin
      case (sel_q)
        SEL_MASK: reg_rd = DATA_W'(mask_q);
        SEL_TRIG: reg_rd = DATA_W'(trig_q);
        SEL_BASE: reg_rd = {base_q, {LVL_W{1'b0}}};
        default:  reg_rd = DATA_W'(isr_q);
      endcase
    end
    if (vec_oe)      rdata = {base_q, lat_lvl};
    else if (rd_any) rdata = reg_rd;
    else             rdata = '0;
    rdata_oe = vec_oe | rd_any;
  end

  a_r4_all_masked_quiet: assert property (@(posedge clk) disable iff (!rst_s_q)
    (&mask_q) |-> !irq_out);

  a_r7_isr_set: assert property (@(posedge clk) disable iff (!rst_s_q)
    (take && lat_valid) |=> isr_q[$past(lat_lvl)]);

  a_r8_spurious_keep: assert property (@(posedge clk) disable iff (!rst_s_q)
    (take && !lat_valid && !eoi) |=> (isr_q == $past(isr_q)));

  a_r9_eoi_one: assert property (@(posedge clk) disable iff (!rst_s_q)
    (eoi && isr_any && !take) |=> ($countones(isr_q) == $countones($past(isr_q)) - 1));
endmodule

// File: tb/sim_prio_irq_ctrl.sv
module sim_prio_irq_ctrl;
  localparam int CLK_P = 10;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       cs = 1'b0, addr = 1'b0, rd = 1'b0, wr = 1'b0, ack = 1'b0;
  logic [7:0] wdata = '0, irq_req = '0;
  logic [7:0] rdata;
  logic       rdata_oe, irq_out;

  int checks = 0;
  int fails = 0;
  bit done = 1'b0;
  logic [7:0] exp_q[$];

  always #(CLK_P/2) clk = ~clk;

  prio_irq_ctrl u0 (
    .clk(clk), .rst_n(rst_n), .cs(cs), .addr(addr), .rd(rd), .wr(wr),
    .wdata(wdata), .rdata(rdata), .rdata_oe(rdata_oe),
    .irq_req(irq_req), .irq_out(irq_out), .ack(ack)
  );

  task automatic chk(input string tag, input logic [7:0] act, input logic [7:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic settle();
    @(negedge clk);
    #(CLK_P/4);
  endtask

  task automatic host_wr(input logic a, input logic [7:0] d, input logic sel = 1'b1);
    @(negedge clk);
    cs = sel; wr = 1'b1; addr = a; wdata = d;
    @(negedge clk);
    cs = 1'b0; wr = 1'b0;
  endtask

  task automatic host_rd(input logic a, output logic [7:0] d);
    @(negedge clk);
    cs = 1'b1; rd = 1'b1; addr = a;
    #(CLK_P/4);
    d = rdata;
    cs = 1'b0; rd = 1'b0;
  endtask

  task automatic set_irq(input logic [7:0] v);
    @(negedge clk);
    irq_req = v;
  endtask

  // driver: pushes the expected vector, then issues the two pulses
  task automatic ack_pair(input logic [7:0] exp_vec);
    exp_q.push_back(exp_vec);
    @(negedge clk);
    ack = 1'b1;
    #(CLK_P/4);
    chk("R6 first pulse drive", {7'd0, rdata_oe}, 8'h00);
    @(negedge clk);
    ack = 1'b0;
    @(negedge clk);
    ack = 1'b1;
    @(negedge clk);
    ack = 1'b0;
  endtask

  // monitor: compares each driven vector with the scoreboard
  initial begin
    forever begin
      @(negedge clk);
      #(CLK_P/4);
      if (ack && rdata_oe) begin
        if (exp_q.size() == 0) chk("R7 unexpected vector", rdata, 8'hxx);
        else chk("R7 R8 vector", rdata, exp_q.pop_front());
      end
    end
  end

  initial begin
    #(CLK_P * 20000);
    if (!done) begin
      fails++;
      checks++;
      $display("FAIL watchdog actual=timeout expected=finish");
      $display("  TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  end

  initial begin
    logic [7:0] d;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);

    // R1 reset state
    #(CLK_P/4);
    chk("R1 irq_out", {7'd0, irq_out}, 8'h00);
    chk("R1 rdata_oe", {7'd0, rdata_oe}, 8'h00);
    host_rd(1'b0, d); chk("R1 pending", d, 8'h00);
    host_rd(1'b1, d); chk("R1 mask", d, 8'h00);

    // R10 configuration: base, then trigger modes
    host_wr(1'b0, 8'h80);
    host_wr(1'b1, 8'h48);
    host_rd(1'b1, d); chk("R10 base readback", d, 8'h48);
    host_wr(1'b0, 8'h40);
    host_wr(1'b1, 8'hF0);
    host_rd(1'b1, d); chk("R10 trigger readback", d, 8'hF0);

    // R2 level mode follows input
    set_irq(8'h04); settle();
    chk("R2 irq_out high", {7'd0, irq_out}, 8'h01);
    host_rd(1'b0, d); chk("R2 pending set", d, 8'h04);
    set_irq(8'h00); settle();
    chk("R2 irq_out low", {7'd0, irq_out}, 8'h00);
    host_rd(1'b0, d); chk("R2 pending cleared", d, 8'h00);

    // R3 edge mode holds
    set_irq(8'h20); set_irq(8'h00); settle();
    host_rd(1'b0, d); chk("R3 edge held", d, 8'h20);
    chk("R3 irq_out", {7'd0, irq_out}, 8'h01);

    // R5 priority and R7 acknowledge
    set_irq(8'h04); settle();
    ack_pair(8'h4A);
    settle();
    chk("R5 same level blocked", {7'd0, irq_out}, 8'h00);
    host_wr(1'b0, 8'hC0);
    host_rd(1'b1, d); chk("R7 isr set", d, 8'h04);
    host_rd(1'b0, d); chk("R7 pending", d, 8'h24);
    set_irq(8'h00);

    // R9 end of interrupt, then serve the edge line
    host_wr(1'b0, 8'h20); settle();
    chk("R9 irq after eoi", {7'd0, irq_out}, 8'h01);
    ack_pair(8'h4D);
    host_wr(1'b0, 8'hC0);
    host_rd(1'b1, d); chk("R9 R7 isr", d, 8'h20);
    host_rd(1'b0, d); chk("R7 edge bit cleared", d, 8'h00);

    // R5 nesting: higher line preempts
    set_irq(8'h08); settle();
    chk("R5 nested irq", {7'd0, irq_out}, 8'h01);
    ack_pair(8'h4B);
    set_irq(8'h00);
    host_rd(1'b1, d); chk("R5 nested isr", d, 8'h28);
    host_wr(1'b0, 8'hE0);
    host_rd(1'b1, d); chk("R9 highest cleared", d, 8'h20);
    host_wr(1'b0, 8'hE0);
    host_rd(1'b1, d); chk("R9 isr empty", d, 8'h00);

    // R4 masking
    host_wr(1'b0, 8'h00);
    host_wr(1'b1, 8'h02);
    set_irq(8'h02); settle();
    chk("R4 masked quiet", {7'd0, irq_out}, 8'h00);
    host_rd(1'b0, d); chk("R4 still recorded", d, 8'h02);
    host_wr(1'b1, 8'h00); settle();
    chk("R4 unmasked", {7'd0, irq_out}, 8'h01);
    set_irq(8'h00); settle();
    chk("R2 drop", {7'd0, irq_out}, 8'h00);

    // R10 chip select gating
    host_wr(1'b1, 8'hFF, 1'b0);
    host_rd(1'b1, d); chk("R10 no cs write", d, 8'h00);

    // R8 spurious acknowledge
    ack_pair(8'h4F);
    host_wr(1'b0, 8'hC0);
    host_rd(1'b1, d); chk("R8 isr unchanged", d, 8'h00);

    repeat (3) @(negedge clk);
    chk("R7 all vectors seen", 8'(exp_q.size()), 8'h00);
    done = 1'b1;
    $display("  TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule